// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models only the tag side of a data cache. For every request it decides whether the addressed line is already held. It then reports a hit or a miss, the number of stall cycles that access costs, and keeps running totals of hits and misses, counted separately for reads and writes. No data is stored. The directory tracks whole line addresses, so it can serve as a performance model beside a processor pipeline, or as the lookup stage of a larger cache.

A byte address is reduced to its line address by dropping the byte-offset bits. The low bits of the line address pick a set, and the full line address is the tag compared against every way of that set. A read that misses installs its line in a victim way. The victim comes either from one rotating pointer shared by all sets, which jumps one extra way after every thirteenth replacement, or from a separate rotating pointer per set. A write that misses installs nothing. The two miss penalties and the replacement mode are inputs that are captured once, when reset is released. An atomic read-modify-write is presented as a read request followed by a write request to the same address.

Top module: `cache_tag_dir`

## Requirements
- R1: After reset every way is empty, all four counters read zero and rsp_valid is low. The first access to any line is therefore a miss.
- R2: With the default geometry (16384 bytes, 4 ways, 32-byte lines, 128 sets), the line address is req_addr[31:5] and the set is req_addr[11:5]. An access hits exactly when a way of that set holds the same line address. Bits [4:0] have no effect on the result.
- R3: rsp_valid is high in the cycle after a cycle with req_valid high and low otherwise. rsp_hit and rsp_penalty belong to that request. One request may be presented every cycle.
- R4: rsp_penalty is 0 on a hit. It is the captured read penalty on a read miss and the captured write penalty on a write miss.
- R5: A read miss writes its line into the victim way. The next access to that line hits, even when it comes in the very next cycle, as the write half of a read-modify-write does.
- R6: A write miss leaves every way unchanged, so a later read of that line still misses.
- R7: With cfg_rr_mode = 0, read misses take victims from one shared pointer that starts at way 0 after reset and moves on by one way, wrapping, after each replacement. On every 13th replacement since reset it moves one further way.
- R8: With cfg_rr_mode = 1, each set has its own pointer that starts at way 0, gives the victim for a read miss in that set, and then moves on by one way with wrap.
- R9: The replacement mode and both penalties are taken from the cfg inputs in the first clock cycle after reset is released. Later changes to those inputs have no effect until the next reset.
- R10: Four counters count read hits, read misses, write hits and write misses. Each accepted request increments exactly one of them. A counter that reaches its maximum value stays there.
- R11: The empty marker can never match a request, not even the all-ones line address 0x7FFFFFF (byte address 0xFFFFFFE0). That line misses on its first read and hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rr_mode | input | 1 | Replacement mode: 0 shared rotating pointer, 1 per-set pointer |
| cfg_load_pen | input | PEN_W (8) | Stall cycles charged for a read miss |
| cfg_store_pen | input | PEN_W (8) | Stall cycles charged for a write miss |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_store | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (32) | Byte address of the access |
| rsp_valid | output | 1 | Result of last cycle's request is present |
| rsp_hit | output | 1 | The request hit |
| rsp_penalty | output | PEN_W (8) | Stall cycles for the request |
| cnt_load_hit | output | CNT_W (64) | Read hit total |
| cnt_load_miss | output | CNT_W (64) | Read miss total |
| cnt_store_hit | output | CNT_W (64) | Write hit total |
| cnt_store_miss | output | CNT_W (64) | Write miss total |

## Verification
The assertions assume that req_is_store and req_addr are known whenever req_valid is high. They also assume that req_valid stays low while reset is asserted, and that the cfg inputs are steady across the release edge and the cycle that follows it. The bench changes its inputs only on falling edges and drives the cfg values before it asserts reset. It holds them through the first request after release, and only later moves them to check that they are ignored. It keeps the address stream inside a few sets, with more lines per set than there are ways, so that hits, evictions and the thirteenth-replacement skip all occur.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

  localparam int NUM_EV = 4;

  typedef enum logic {
    REPL_SHARED  = 1'b0,
    REPL_PER_SET = 1'b1
  } repl_mode_e;

  // {is_store, is_miss}
  typedef enum logic [1:0] {
    EV_LD_HIT  = 2'd0,
    EV_LD_MISS = 2'd1,
    EV_ST_HIT  = 2'd2,
    EV_ST_MISS = 2'd3
  } stat_ev_e;

endpackage

// File: rtl/ctd_tag_array.sv
module ctd_tag_array #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 28,
  parameter int SET_W = 7,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]  match,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [TAG_W-1:0] tags_q [SETS][WAYS];

  // Every way starts at the all-ones empty marker.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          tags_q[s][w] <= '1;
        end
      end
    end else if (wr_en) begin
      tags_q[wr_set][wr_way] <= wr_tag;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (tags_q[rd_set][w] == rd_tag);
  end

endmodule

// File: rtl/ctd_victim_sel.sv
module ctd_victim_sel
  import ctd_pkg::*;
#(
  parameter int SETS        = 128,
  parameter int WAYS        = 4,
  parameter int SET_W       = 7,
  parameter int WAY_W       = 2,
  parameter int SKIP_PERIOD = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  repl_mode_e       mode,
  input  logic [SET_W-1:0] set_idx,
  input  logic             advance,
  output logic [WAY_W-1:0] victim
);

  localparam int SKIP_W = $clog2(SKIP_PERIOD + 1);
  localparam logic [WAY_W-1:0]  LAST_WAY  = WAY_W'(WAYS - 1);
  localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(SKIP_PERIOD - 1);

  logic [WAY_W-1:0]  glob_q, glob_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [WAY_W-1:0]  rr_q [SETS];
  logic [WAY_W-1:0]  rr_d [SETS];

  function automatic logic [WAY_W-1:0] next_way(input logic [WAY_W-1:0] w);
    return (w == LAST_WAY) ? '0 : w + 1'b1;
  endfunction

  always_comb begin
    glob_d = glob_q;
    skip_d = skip_q;
    rr_d   = rr_q;
    if (advance) begin
      if (mode == REPL_PER_SET) begin
        rr_d[set_idx] = next_way(rr_q[set_idx]);
      end else begin
        glob_d = next_way(glob_q);
        if (skip_q == SKIP_LAST) begin
          skip_d = '0;
          glob_d = next_way(next_way(glob_q));
        end else begin
          skip_d = skip_q + 1'b1;
        end
      end
    end
  end

  assign victim = (mode == REPL_PER_SET) ? rr_q[set_idx] : glob_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
      skip_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
      end
    end else if (advance) begin
      glob_q <= glob_d;
      skip_q <= skip_d;
      rr_q   <= rr_d;
    end
  end

endmodule

// File: rtl/ctd_stats.sv
module ctd_stats
  import ctd_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_valid,
  input  stat_ev_e                      ev_kind,
  output logic [NUM_EV-1:0][CNT_W-1:0]  cnt_o
);

  for (genvar k = 0; k < NUM_EV; k++) begin : g_cnt
    logic [CNT_W-1:0] q, d;
    logic             en;

    always_comb begin
      en = ev_valid && (ev_kind == stat_ev_e'(2'(k))) && (q != {CNT_W{1'b1}});
      d  = q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign cnt_o[k] = q;
  end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import ctd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int NUM_WAYS    = 4,
  parameter int LINE_BYTES  = 32,
  parameter int PEN_W       = 8,
  parameter int CNT_W       = 64,
  parameter int SKIP_PERIOD = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rr_mode,
  input  logic [PEN_W-1:0]  cfg_load_pen,
  input  logic [PEN_W-1:0]  cfg_store_pen,
  input  logic              req_valid,
  input  logic              req_is_store,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PEN_W-1:0]  rsp_penalty,
  output logic [CNT_W-1:0]  cnt_load_hit,
  output logic [CNT_W-1:0]  cnt_load_miss,
  output logic [CNT_W-1:0]  cnt_store_hit,
  output logic [CNT_W-1:0]  cnt_store_miss
);

  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int WAY_W    = $clog2(NUM_WAYS);
  localparam int NUM_SETS = CACHE_BYTES / (LINE_BYTES * NUM_WAYS);
  localparam int SET_W    = $clog2(NUM_SETS);
  localparam int LINE_W   = ADDR_W - OFF_W;
  localparam int TAG_W    = LINE_W + 1;   // extra MSB keeps real tags off the empty marker

  // Configuration captured in the first cycle after reset release
  logic             cfg_done_q;
  logic             rr_mode_q;
  logic [PEN_W-1:0] ld_pen_q, st_pen_q;
  repl_mode_e       mode_eff;
  logic [PEN_W-1:0] ld_pen_eff, st_pen_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done_q <= 1'b0;
      rr_mode_q  <= 1'b0;
      ld_pen_q   <= '0;
      st_pen_q   <= '0;
    end else if (!cfg_done_q) begin
      cfg_done_q <= 1'b1;
      rr_mode_q  <= cfg_rr_mode;
      ld_pen_q   <= cfg_load_pen;
      st_pen_q   <= cfg_store_pen;
    end
  end

  always_comb begin
    mode_eff   = repl_mode_e'(cfg_done_q ? rr_mode_q : cfg_rr_mode);
    ld_pen_eff = cfg_done_q ? ld_pen_q : cfg_load_pen;
    st_pen_eff = cfg_done_q ? st_pen_q : cfg_store_pen;
  end

  // Address decode and lookup
  logic [LINE_W-1:0] line_addr;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  lookup_tag;
  logic [NUM_WAYS-1:0] way_match;
  logic              way_hit;
  logic              fill;
  logic [WAY_W-1:0]  victim;
  stat_ev_e          ev_kind;

  always_comb begin
    line_addr  = req_addr[ADDR_W-1:OFF_W];
    set_idx    = line_addr[SET_W-1:0];
    lookup_tag = {1'b0, line_addr};
    way_hit    = |way_match;
    fill       = req_valid && !req_is_store && !way_hit;
    ev_kind    = stat_ev_e'({req_is_store, !way_hit});
  end

  ctd_tag_array #(
    .SETS  (NUM_SETS),
    .WAYS  (NUM_WAYS),
    .TAG_W (TAG_W),
    .SET_W (SET_W),
    .WAY_W (WAY_W)
  ) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_set (set_idx),
    .rd_tag (lookup_tag),
    .match  (way_match),
    .wr_en  (fill),
    .wr_set (set_idx),
    .wr_way (victim),
    .wr_tag (lookup_tag)
  );

  ctd_victim_sel #(
    .SETS        (NUM_SETS),
    .WAYS        (NUM_WAYS),
    .SET_W       (SET_W),
    .WAY_W       (WAY_W),
    .SKIP_PERIOD (SKIP_PERIOD)
  ) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_eff),
    .set_idx (set_idx),
    .advance (fill),
    .victim  (victim)
  );

  logic [NUM_EV-1:0][CNT_W-1:0] stat_cnt;

  ctd_stats #(
    .CNT_W (CNT_W)
  ) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (req_valid),
    .ev_kind  (ev_kind),
    .cnt_o    (stat_cnt)
  );

  assign cnt_load_hit   = stat_cnt[EV_LD_HIT];
  assign cnt_load_miss  = stat_cnt[EV_LD_MISS];
  assign cnt_store_hit  = stat_cnt[EV_ST_HIT];
  assign cnt_store_miss = stat_cnt[EV_ST_MISS];

  // Response stage
  logic             rsp_valid_q, rsp_hit_q, rsp_hit_d;
  logic [PEN_W-1:0] rsp_pen_q, rsp_pen_d;

  always_comb begin
    rsp_hit_d = way_hit;
    if (way_hit) begin
      rsp_pen_d = '0;
    end else if (req_is_store) begin
      rsp_pen_d = st_pen_eff;
    end else begin
      rsp_pen_d = ld_pen_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_pen_q   <= '0;
    end else begin
      rsp_valid_q <= req_valid;
      if (req_valid) begin
        rsp_hit_q <= rsp_hit_d;
        rsp_pen_q <= rsp_pen_d;
      end
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_hit     = rsp_hit_q;
  assign rsp_penalty = rsp_pen_q;

endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
  parameter int NUM_WAYS = 4,
  parameter int PEN_W    = 8,
  parameter int CNT_W    = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_is_store,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic [PEN_W-1:0]    rsp_penalty,
  input logic                cfg_done_q,
  input logic                rr_mode_q,
  input logic [PEN_W-1:0]    ld_pen_q,
  input logic [PEN_W-1:0]    st_pen_q,
  input logic [NUM_WAYS-1:0] way_match,
  input logic [CNT_W-1:0]    cnt_load_hit,
  input logic [CNT_W-1:0]    cnt_load_miss,
  input logic [CNT_W-1:0]    cnt_store_hit,
  input logic [CNT_W-1:0]    cnt_store_miss
);

  // High once at least one clock edge has passed since reset release
  logic hist_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= 1'b1;
  end

  // R3: a response appears exactly one cycle after each request
  a_r3_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q |-> (rsp_valid == $past(req_valid)));

  // R2: a line is held in at most one way of a set
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_match));

  // R4: hits are free
  a_r4_hit_free: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_penalty == '0));

  // R4: read miss charges the captured read penalty
  a_r4_load_miss_pen: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && rsp_valid && !rsp_hit && !$past(req_is_store)) |-> (rsp_penalty == ld_pen_q));

  // R4: write miss charges the captured write penalty
  a_r4_store_miss_pen: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && rsp_valid && !rsp_hit && $past(req_is_store)) |-> (rsp_penalty == st_pen_q));

  // R10: at most one counter moves per cycle
  a_r10_one_counter: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q |-> ($countones({cnt_load_hit   != $past(cnt_load_hit),
                            cnt_load_miss  != $past(cnt_load_miss),
                            cnt_store_hit  != $past(cnt_store_hit),
                            cnt_store_miss != $past(cnt_store_miss)}) <= 1));

  // R10: a full counter stays full
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && ($past(cnt_load_hit) == {CNT_W{1'b1}})) |-> (cnt_load_hit == {CNT_W{1'b1}}));

  // R9: captured configuration never moves after capture
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_q && $past(cfg_done_q)) |-> ($stable(ld_pen_q) && $stable(st_pen_q) && $stable(rr_mode_q)));

endmodule

bind cache_tag_dir cache_tag_dir_chk #(
  .NUM_WAYS (NUM_WAYS),
  .PEN_W    (PEN_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_is_store   (req_is_store),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_penalty    (rsp_penalty),
  .cfg_done_q     (cfg_done_q),
  .rr_mode_q      (rr_mode_q),
  .ld_pen_q       (ld_pen_q),
  .st_pen_q       (st_pen_q),
  .way_match      (way_match),
  .cnt_load_hit   (cnt_load_hit),
  .cnt_load_miss  (cnt_load_miss),
  .cnt_store_hit  (cnt_store_hit),
  .cnt_store_miss (cnt_store_miss)
);

// File: tb/tb_cache_tag_dir.sv
module tb_cache_tag_dir;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 6;     // narrow counters so saturation is reachable
  localparam int PW         = 8;
  localparam longint unsigned CMAX = (64'd1 << CW) - 1;
  localparam int MSETS = 128;
  localparam int MWAYS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_rr_mode = 1'b0;
  logic [PW-1:0] cfg_load_pen = 8'd30;
  logic [PW-1:0] cfg_store_pen = 8'd5;
  logic          req_valid = 1'b0;
  logic          req_is_store = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          rsp_valid, rsp_hit;
  logic [PW-1:0] rsp_penalty;
  logic [CW-1:0] cnt_load_hit, cnt_load_miss, cnt_store_hit, cnt_store_miss;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_dir #(.CNT_W(CW), .PEN_W(PW)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_rr_mode    (cfg_rr_mode),
    .cfg_load_pen   (cfg_load_pen),
    .cfg_store_pen  (cfg_store_pen),
    .req_valid      (req_valid),
    .req_is_store   (req_is_store),
    .req_addr       (req_addr),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_penalty    (rsp_penalty),
    .cnt_load_hit   (cnt_load_hit),
    .cnt_load_miss  (cnt_load_miss),
    .cnt_store_hit  (cnt_store_hit),
    .cnt_store_miss (cnt_store_miss)
  );

  int errors = 0;
  int checks = 0;

  // Behavioural reference state
  int              mtag [MSETS][MWAYS];   // -1 = empty
  int              mrr  [MSETS];
  int              mglob, mskip;
  bit              mmode;
  int              mldpen, mstpen;
  longint unsigned mcnt [4];              // 0 ld hit, 1 ld miss, 2 st hit, 3 st miss
  bit              exp_hit;
  int              exp_pen;

  task automatic chk(string rq, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < MSETS; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < MWAYS; w++) mtag[s][w] = -1;
    end
    mglob = 0;
    mskip = 0;
    for (int k = 0; k < 4; k++) mcnt[k] = 0;
    mmode  = cfg_rr_mode;
    mldpen = int'(cfg_load_pen);
    mstpen = int'(cfg_store_pen);
  endtask

  task automatic model_access(bit st, logic [31:0] a);
    int line, set, v, k;
    line = int'(a >> 5);
    set  = line % MSETS;
    exp_hit = 1'b0;
    for (int w = 0; w < MWAYS; w++) if (mtag[set][w] == line) exp_hit = 1'b1;
    k = (st ? 2 : 0) + (exp_hit ? 0 : 1);
    if (mcnt[k] < CMAX) mcnt[k]++;
    exp_pen = exp_hit ? 0 : (st ? mstpen : mldpen);
    if (!st && !exp_hit) begin
      if (mmode) begin
        v = mrr[set];
        mrr[set] = (v + 1) % MWAYS;
      end else begin
        v = mglob;
        mglob = (mglob + 1) % MWAYS;
        mskip++;
        if (mskip == 13) begin
          mskip = 0;
          mglob = (mglob + 1) % MWAYS;
        end
      end
      mtag[set][v] = line;
    end
  endtask

  task automatic check_counters(string rq);
    chk(rq, "cnt_load_hit",   cnt_load_hit,   mcnt[0]);
    chk(rq, "cnt_load_miss",  cnt_load_miss,  mcnt[1]);
    chk(rq, "cnt_store_hit",  cnt_store_hit,  mcnt[2]);
    chk(rq, "cnt_store_miss", cnt_store_miss, mcnt[3]);
  endtask

  // Drive on a falling edge, let the rising edge act, compare on the next falling edge
  task automatic step(string rq, bit v, bit st, logic [31:0] a);
    req_valid    = v;
    req_is_store = st;
    req_addr     = a;
    @(posedge clk);
    if (v) model_access(st, a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rq, "rsp_valid", rsp_valid, v);
    if (v) begin
      chk(rq, "rsp_hit", rsp_hit, exp_hit);
      chk(rq, "rsp_penalty", rsp_penalty, exp_pen);
    end
    check_counters(rq);
  endtask

  task automatic do_reset(bit mode, int ldp, int stp);
    @(negedge clk);
    req_valid     = 1'b0;
    cfg_rr_mode   = mode;
    cfg_load_pen  = PW'(ldp);
    cfg_store_pen = PW'(stp);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // R1: reset state visible before any post-reset edge
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    check_counters("R1");
  endtask

  task automatic stream(string rq, int n, logic [31:0] seed);
    logic [31:0] x;
    logic [31:0] a;
    x = seed;
    for (int i = 0; i < n; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      a = 32'h5000_0000 + ({29'd0, x[10:8]} << 12) + ({29'd0, x[6:4]} << 5) + {27'd0, x[15:11]};
      step(rq, (x[1:0] != 2'b00), (x[3:2] == 2'b11), a);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0, 30, 5);

    // R1 and R11: first access misses; all-ones line is a real line
    step("R11", 1, 0, 32'hFFFF_FFE0);
    step("R11", 1, 0, 32'hFFFF_FFFC);
    step("R1",  1, 0, 32'h0000_0000);

    // R2: byte offset ignored, next line distinct
    step("R2", 1, 0, 32'h1000_0004);
    step("R2", 1, 0, 32'h1000_001C);
    step("R2", 1, 0, 32'h1000_0020);

    // R3: idle cycle gives no response
    step("R3", 0, 0, 32'h1000_0004);
    step("R3", 1, 1, 32'h1000_0004);

    // R6: write miss does not allocate; R4 penalties
    step("R6", 1, 1, 32'h2000_0000);
    step("R6", 1, 0, 32'h2000_0000);
    step("R4", 1, 1, 32'h2000_0000);

    // R5: read-modify-write as back-to-back read then write
    step("R5", 1, 0, 32'h3000_0040);
    step("R5", 1, 1, 32'h3000_0040);

    // R7: many lines in one set drive the shared pointer through the skip
    for (int k = 0; k < 20; k++) step("R7", 1, 0, 32'h4000_00A0 + 32'(k) * 32'h1000);
    for (int k = 0; k < 20; k++) step("R7", 1, 0, 32'h4000_00A0 + 32'(k) * 32'h1000);
    stream("R7", 400, 32'h1234_5678);

    // R9: later cfg changes are ignored
    cfg_load_pen  = 8'd99;
    cfg_store_pen = 8'd77;
    cfg_rr_mode   = 1'b1;
    stream("R9", 200, 32'h0BAD_F00D);

    // R8: per-set pointers
    do_reset(1'b1, 12, 3);
    for (int k = 0; k < 6; k++) step("R8", 1, 0, 32'h6000_0020 + 32'(k) * 32'h1000);
    step("R8", 1, 0, 32'h6000_0040);
    for (int k = 0; k < 6; k++) step("R8", 1, 0, 32'h6000_0020 + 32'(k) * 32'h1000);
    stream("R8", 400, 32'hCAFE_0001);

    // R10: counter saturation
    do_reset(1'b0, 30, 5);
    for (int k = 0; k < 70; k++) step("R10", 1, 0, 32'h7000_0100);
    chk("R10", "cnt_load_hit saturated", cnt_load_hit, CMAX);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule